// File: doc/BRIEF.md
# Prefetch Read Serializer

This block sits between a wide memory-core read port and a narrow data pin group. Each load hands it one prefetched word. The block then sends that word out as a burst of narrow beats, one beat per cycle of its single fast clock. In half-prefetch mode only the lower two lanes of the word are sent, which gives two beats per core cycle. This matches data moving on both edges of an I/O clock that runs at the core rate. In full-prefetch mode all four lanes are sent, which gives four beats per core cycle. This matches both edges of an I/O clock at twice the core rate. The core rate itself is the same in both modes.

The double-edge behaviour is modelled as one rising-edge clock at the beat rate. A lane counter picks which register drives the output, so no logic is clocked on a falling edge. Beats leave lowest lane first. The block accepts a new word only when it is idle, or on the final beat of the current word. A word loaded on the final beat follows with no idle cycle between the two bursts. Between bursts the valid flag is low and the data output keeps its last beat.

Top module: `pfs_serializer`

## Requirements
- R1: After reset, `dq_o` is zero and `dq_vld_o` is low.
- R2: An accepted load with `full_i`=1 at clock edge E puts lanes 0,1,2,3 of `word_i` (lane k = bits [k*N +: N]) on `dq_o` in the four cycles after E, in that order.
- R3: An accepted load with `full_i`=0 sends only lanes 0 and 1. Bits of lanes 2 and 3 never appear on `dq_o`.
- R4: `dq_vld_o` is high for exactly the beats of an accepted word: four cycles in full mode, two in half mode.
- R5: A load is accepted only while idle or on the final beat of the current word. A load raised on any earlier beat is ignored and the current burst continues unchanged.
- R6: A load accepted on the final beat makes the first beat of the new word follow directly, with `dq_vld_o` staying high.
- R7: When no word is being sent, `dq_vld_o` is low and `dq_o` keeps the last beat sent.
- R8: The mode and data are taken at the accepting edge. Changes to `full_i` or `word_i` during a burst have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat-rate clock (rising edge only) |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_i | input | 1 | Load request for `word_i` |
| full_i | input | 1 | 1: four-lane prefetch, 0: two-lane prefetch |
| word_i | input | N*LANES | Prefetched word, lane 0 in the low bits |
| dq_o | output | N | Serialized beat |
| dq_vld_o | output | 1 | High while `dq_o` carries a beat |

## Verification
The assertions assume that `ld_i`, `full_i` and `word_i` hold known values at every rising edge after reset. They also assume the load strobe is the only thing that starts a burst. Nothing is assumed about how long the load is held, because refusing a load is part of the checked behaviour. The stimulus changes every input on the falling edge, so each value is settled at the rising edge that samples it. It also deliberately toggles mode and data in the middle of bursts, to show that only the accepting edge matters.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
    typedef enum logic {
        PF_HALF = 1'b0,
        PF_FULL = 1'b1
    } pf_mode_e;
endpackage

// File: rtl/pfs_phase.sv
module pfs_phase #(
    parameter int LANES = 4,
    localparam int IW = $clog2(LANES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_i,
    input  logic          full_i,
    output logic          accept_o,
    output logic          upd_o,
    output logic [IW-1:0] sel_o,
    output logic          vld_o
);
    import pfs_pkg::*;

    localparam logic [IW-1:0] LAST_FULL = IW'(LANES - 1);
    localparam logic [IW-1:0] LAST_HALF = IW'(LANES / 2 - 1);

    typedef struct packed {
        logic          active;
        logic [IW-1:0] idx;
        pf_mode_e      mode;
    } phase_t;

    phase_t s_d, s_q;
    logic [IW-1:0] last;
    logic acc;

    always_comb begin
        s_d  = s_q;
        last = (s_q.mode == PF_FULL) ? LAST_FULL : LAST_HALF;
        acc  = ld_i && (!s_q.active || s_q.idx == last);
        if (acc) begin
            s_d.active = 1'b1;
            s_d.idx    = '0;
            s_d.mode   = full_i ? PF_FULL : PF_HALF;
        end else if (s_q.active) begin
            if (s_q.idx == last) s_d.active = 1'b0;
            else                 s_d.idx    = s_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{active: 1'b0, idx: '0, mode: PF_HALF};
        else        s_q <= s_d;
    end

    assign accept_o = acc;
    assign upd_o    = acc || (s_q.active && s_q.idx != last);
    assign sel_o    = s_d.idx;
    assign vld_o    = s_q.active;
endmodule

// File: rtl/pfs_bank.sv
module pfs_bank #(
    parameter int N     = 8,
    parameter int LANES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cap_i,
    input  logic [N*LANES-1:0]        word_i,
    output logic [LANES-1:0][N-1:0]   lane_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [N-1:0] lane_d, lane_q;
        always_comb begin
            lane_d = lane_q;
            if (cap_i) lane_d = word_i[g*N +: N];
        end
        always_ff @(posedge clk) begin
            if (!rst_n) lane_q <= '0;
            else        lane_q <= lane_d;
        end
        assign lane_o[g] = lane_q;
    end
endmodule

// File: rtl/pfs_beat.sv
module pfs_beat #(
    parameter int N     = 8,
    parameter int LANES = 4,
    localparam int IW = $clog2(LANES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd_i,
    input  logic                    acc_i,
    input  logic [N-1:0]            first_i,
    input  logic [LANES-1:0][N-1:0] lane_i,
    input  logic [IW-1:0]           sel_i,
    output logic [N-1:0]            dq_o
);
    logic [N-1:0] beat_d, beat_q;

    always_comb begin
        beat_d = beat_q;
        if (upd_i) beat_d = acc_i ? first_i : lane_i[sel_i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) beat_q <= '0;
        else        beat_q <= beat_d;
    end

    assign dq_o = beat_q;
endmodule

// File: rtl/pfs_serializer.sv
module pfs_serializer #(
    parameter int N     = 8,
    parameter int LANES = 4,
    localparam int IW = $clog2(LANES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_i,
    input  logic               full_i,
    input  logic [N*LANES-1:0] word_i,
    output logic [N-1:0]       dq_o,
    output logic               dq_vld_o
);
    logic acc, upd;
    logic [IW-1:0] sel;
    logic [LANES-1:0][N-1:0] lanes;

    pfs_phase #(.LANES(LANES)) u_phase (
        .clk(clk), .rst_n(rst_n), .ld_i(ld_i), .full_i(full_i),
        .accept_o(acc), .upd_o(upd), .sel_o(sel), .vld_o(dq_vld_o)
    );

    pfs_bank #(.N(N), .LANES(LANES)) u_bank (
        .clk(clk), .rst_n(rst_n), .cap_i(acc), .word_i(word_i), .lane_o(lanes)
    );

    pfs_beat #(.N(N), .LANES(LANES)) u_beat (
        .clk(clk), .rst_n(rst_n), .upd_i(upd), .acc_i(acc),
        .first_i(word_i[N-1:0]), .lane_i(lanes), .sel_i(sel), .dq_o(dq_o)
    );
endmodule

// File: rtl/pfs_chk.sv
module pfs_chk #(
    parameter int N     = 8,
    parameter int LANES = 4,
    localparam int CW = $clog2(LANES) + 2
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ld_i,
    input logic         full_i,
    input logic [N-1:0] w0_i,
    input logic [N-1:0] dq_o,
    input logic         dq_vld_o,
    input logic         acc_i
);
    logic [CW-1:0] run_q;
    logic          mode_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            mode_q <= 1'b0;
        end else if (acc_i) begin
            run_q  <= CW'(1);
            mode_q <= full_i;
        end else if (dq_vld_o) begin
            run_q  <= run_q + 1'b1;
        end
    end

    p_accept_vld_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_i |=> dq_vld_o);
    p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_i |=> dq_o == $past(w0_i));
    p_run_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dq_vld_o |-> run_q <= CW'(LANES));
    p_run_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_vld_o && !mode_q) |-> run_q <= CW'(LANES / 2));
    p_accept_point_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_i |-> (!dq_vld_o || run_q == (mode_q ? CW'(LANES) : CW'(LANES / 2))));
    p_no_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_i && dq_vld_o) |=> dq_vld_o);
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_vld_o |=> (dq_vld_o || $stable(dq_o)));
    p_end_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dq_vld_o) |-> $stable(dq_o));
endmodule

bind pfs_serializer pfs_chk #(.N(N), .LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .ld_i(ld_i), .full_i(full_i),
    .w0_i(word_i[N-1:0]), .dq_o(dq_o), .dq_vld_o(dq_vld_o), .acc_i(acc)
);

// File: tb/pfs_serializer_test.sv
`timescale 1ns/1ps
module pfs_serializer_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ld, full;
    logic [31:0] word;
    logic [7:0]  dq;
    logic        vld;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pfs_serializer #(.N(8), .LANES(4)) uut (
        .clk(clk), .rst_n(rst_n), .ld_i(ld), .full_i(full),
        .word_i(word), .dq_o(dq), .dq_vld_o(vld)
    );

    // {full, word}
    localparam logic [32:0] VEC [8] = '{
        {1'b1, 32'h4433_2211}, {1'b0, 32'hDEAD_BEEF},
        {1'b1, 32'h0000_0000}, {1'b1, 32'hFFFF_FFFF},
        {1'b0, 32'h5A5A_A5A5}, {1'b1, 32'h8001_7F80},
        {1'b0, 32'h1234_00FF}, {1'b1, 32'hC3E1_0F96}
    };

    function automatic logic [7:0] lane(input logic [31:0] w, input int k);
        return w[k*8 +: 8];
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, got, exp);
        end
    endtask

    initial begin
        #(4 * 50000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] w1, w2;
        rst_n = 1'b0; ld = 1'b0; full = 1'b0; word = '0;
        repeat (3) @(negedge clk);
        chk("R1 dq", 32'(dq), 32'h0);
        chk("R1 vld", 32'(vld), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 vld after release", 32'(vld), 32'h0);

        // table walk: R2, R3, R4, R7, R8
        for (int v = 0; v < 8; v++) begin
            int nb;
            w1 = VEC[v][31:0];
            nb = VEC[v][32] ? 4 : 2;
            ld = 1'b1; full = VEC[v][32]; word = w1;
            @(negedge clk);
            ld = 1'b0; full = ~full; word = ~w1;   // R8: ignored mid-burst
            for (int k = 0; k < nb; k++) begin
                chk(VEC[v][32] ? "R2 beat" : "R3 beat", 32'(dq), 32'(lane(w1, k)));
                chk("R4 vld high", 32'(vld), 32'h1);
                @(negedge clk);
            end
            chk("R4 vld low after burst", 32'(vld), 32'h0);
            chk("R7 hold", 32'(dq), 32'(lane(w1, nb - 1)));
            @(negedge clk);
            chk("R7 still held", 32'(dq), 32'(lane(w1, nb - 1)));
        end

        // R5: load held on non-final beats is ignored
        w1 = 32'hA1B2_C3D4; w2 = 32'h1122_3344;
        ld = 1'b1; full = 1'b1; word = w1;
        @(negedge clk);
        word = w2; full = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk("R5 beat", 32'(dq), 32'(lane(w1, k)));
            if (k == 3) ld = 1'b0;
            @(negedge clk);
        end
        chk("R5 burst ended", 32'(vld), 32'h0);

        // R6: load on final beat chains without a gap
        w1 = 32'h0F0E_0D0C; w2 = 32'h9988_7766;
        @(negedge clk);
        ld = 1'b1; full = 1'b0; word = w1;
        @(negedge clk);
        ld = 1'b0;
        chk("R6 first word b0", 32'(dq), 32'(lane(w1, 0)));
        @(negedge clk);
        chk("R6 first word b1", 32'(dq), 32'(lane(w1, 1)));
        ld = 1'b1; full = 1'b1; word = w2;
        @(negedge clk);
        ld = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk("R6 chained beat", 32'(dq), 32'(lane(w2, k)));
            chk("R6 vld stays high", 32'(vld), 32'h1);
            @(negedge clk);
        end
        chk("R6 end", 32'(vld), 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule